// File: doc/BRIEF.md
# Processor Package Low-Power State Controller

This block tracks the power state of a multi-core processor package. It watches per-core flags that report a halt-type instruction, a stop-clock request from the platform, the acknowledge strobe of the stop-grant bus cycle, bus snoop activity and the break events that wake a sleeping package. From these it keeps a single package state: running, halted, entering stop grant, in stop grant, or servicing a snoop from one of the two sleep states.

The halted state is reached only when every core has halted. A stop-clock request moves the package into a timed entry phase. The stop-grant state takes effect a fixed number of bus clocks after the acknowledge response is seen. While stop-clock is held, break events are not serviced. They are collected and handed out, one pulse each, when the package returns to running. A snoop seen in either sleep state parks the controller in a matching snoop substate until the snoop is serviced, and the controller then goes back to where it was. An extended-mode enable marks the sleep states as their lower-voltage variants.

Top module: `lps_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, `pstate` is 0 (running) and `pstate_ext`, `halt_cycle_req` and `replay_evt` are all 0. State codes are: 0 running, 1 halted, 2 halted-snoop, 3 stop-grant entry, 4 stop grant, 5 stop-grant snoop.
- R2: From running, with `stop_req` low and no break event in the same cycle, the state goes to halted on the next edge only if every bit of `core_halted` is 1. Any clear bit keeps it running. `halt_cycle_req` is high for exactly the first cycle of halted after that move.
- R3: In halted, any one of `brk_smi`, `brk_init`, `brk_nmi`, `brk_intr`, `brk_fsb` or `brk_reset` returns the state to running on the next edge, ahead of a snoop or `stop_req`. In halted-snoop, only `brk_reset` does this and the other break inputs have no effect.
- R4: `stop_req` high in running or halted moves the state to stop-grant entry. Stop grant (4) shows exactly SG_DELAY (default 20) clocks after the edge that samples `sgack_resp` high during entry. Without that strobe, entry persists.
- R5: `snoop_hit` in halted moves to halted-snoop, and in stop grant moves to stop-grant snoop. The state stays there until `snoop_done` and then returns to the state it came from. `snoop_hit` is ignored in running and in entry.
- R6: `stop_req` low in entry or stop grant leaves on the next edge. The state goes back to halted if the stop request came from halted and nothing is latched. Otherwise it goes to running. In stop-grant snoop, `stop_req` low is not acted on until the snoop is serviced.
- R7: In entry, stop grant and stop-grant snoop, break events are latched into `replay_evt` bits: bit 0 SMI, bit 1 INIT, bit 2 NMI, bit 3 INTR (`brk_fsb` also sets bit 3). When the state returns to running from those states, `replay_evt` shows the latched set for exactly one cycle, each bit once however often its event occurred, and the latch then clears.
- R8: `brk_reset` in entry, stop grant or stop-grant snoop leaves the state unchanged but clears the latched events and forgets the halted origin, so the later exit goes to running with `replay_evt` 0. In running or halted it forces running.
- R9: `pstate_ext` equals `ext_en` in states 1, 2, 4 and 5, and is 0 in running and in entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset of the block |
| core_halted | input | NCORES | Per-core halt-instruction-executed flags |
| ext_en | input | 1 | Extended low-voltage variants enabled |
| stop_req | input | 1 | Stop-clock request, active high level |
| sgack_resp | input | 1 | Response-phase strobe of the stop-grant acknowledge cycle |
| snoop_hit | input | 1 | Snoop detected on the bus |
| snoop_done | input | 1 | Snoop serviced by any agent |
| brk_smi | input | 1 | System management interrupt event |
| brk_init | input | 1 | INIT event |
| brk_nmi | input | 1 | Non-maskable interrupt event |
| brk_intr | input | 1 | Maskable interrupt event |
| brk_fsb | input | 1 | Interrupt message from the bus |
| brk_reset | input | 1 | Package reset event |
| pstate | output | 3 | Current package state code |
| pstate_ext | output | 1 | State is the extended variant |
| halt_cycle_req | output | 1 | Request to issue the halt bus cycle |
| replay_evt | output | 4 | One-cycle replay of latched break events |

## Verification
The assertions assume that `snoop_done` arrives only after a snoop has begun, and that `sgack_resp` matters only while the controller waits in entry. The stop-grant delay assertion counts from the first strobe seen in entry and ignores later strobes. The stimulus holds `stop_req` for long stretches so that the 20-clock window can complete. It sends snoop, acknowledge and break strobes as single-cycle pulses at modest rates, so every state and every exit path is visited many times with a fixed seed.

// File: rtl/lps_pkg.sv
package lps_pkg;

    typedef enum logic [2:0] {
        PS_RUN      = 3'd0,
        PS_HALT     = 3'd1,
        PS_HALT_SNP = 3'd2,
        PS_SG_ENTRY = 3'd3,
        PS_SG       = 3'd4,
        PS_SG_SNP   = 3'd5
    } pstate_e;

    localparam int NUM_EVT  = 4;
    localparam int EVT_SMI  = 0;
    localparam int EVT_INIT = 1;
    localparam int EVT_NMI  = 2;
    localparam int EVT_INTR = 3;

    typedef logic [NUM_EVT-1:0] evt_vec_t;

    function automatic logic holds_events(pstate_e s);
        return (s == PS_SG_ENTRY) || (s == PS_SG) || (s == PS_SG_SNP);
    endfunction

    function automatic logic is_deep(pstate_e s);
        return (s == PS_HALT) || (s == PS_HALT_SNP) || (s == PS_SG) || (s == PS_SG_SNP);
    endfunction

endpackage

// File: rtl/lps_evt_latch.sv
module lps_evt_latch
    import lps_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     capture,
    input  evt_vec_t evts,
    input  logic     wipe,
    input  logic     drain,
    output logic     pend_any,
    output evt_vec_t replay
);
    evt_vec_t held_q;
    evt_vec_t pend;

    always_comb begin
        if (wipe) pend = '0;
        else      pend = held_q | (capture ? evts : '0);
    end

    assign pend_any = |pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
            replay <= '0;
        end else begin
            held_q <= drain ? '0 : pend;
            replay <= drain ? pend : '0;
        end
    end
endmodule

// File: rtl/lps_sg_timer.sv
module lps_sg_timer #(
    parameter int SG_DELAY = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic ack,
    output logic done
);
    localparam int WCNT = $clog2(SG_DELAY + 1);

    logic            armed_q;
    logic [WCNT-1:0] left_q;

    assign done = run && armed_q && (left_q == WCNT'(1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            armed_q <= 1'b0;
            left_q  <= '0;
        end else if (!armed_q) begin
            if (ack) begin
                armed_q <= 1'b1;
                left_q  <= WCNT'(SG_DELAY);
            end
        end else if (left_q != '0) begin
            left_q <= left_q - WCNT'(1);
        end
    end
endmodule

// File: rtl/lps_fsm.sv
module lps_fsm
    import lps_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    all_halted,
    input  logic    stop_req,
    input  logic    snoop_hit,
    input  logic    snoop_done,
    input  logic    evt_any,
    input  logic    brk_reset,
    input  logic    pend_any,
    input  logic    timer_done,
    output pstate_e state,
    output logic    drain,
    output logic    halt_cycle_req
);
    pstate_e nxt;
    logic    from_halt_q, nfh, fh_eff, wake;

    assign wake   = evt_any | brk_reset;
    assign fh_eff = from_halt_q & ~brk_reset;

    always_comb begin
        nxt   = state;
        nfh   = from_halt_q;
        drain = 1'b0;
        unique case (state)
            PS_RUN: begin
                if (stop_req) begin
                    nxt = PS_SG_ENTRY;
                    nfh = 1'b0;
                end else if (all_halted && !wake) begin
                    nxt = PS_HALT;
                end
            end
            PS_HALT: begin
                if (wake)           nxt = PS_RUN;
                else if (snoop_hit) nxt = PS_HALT_SNP;
                else if (stop_req) begin
                    nxt = PS_SG_ENTRY;
                    nfh = 1'b1;
                end
            end
            PS_HALT_SNP: begin
                if (brk_reset)       nxt = PS_RUN;
                else if (snoop_done) nxt = PS_HALT;
            end
            PS_SG_ENTRY, PS_SG: begin
                nfh = fh_eff;
                if (!stop_req) begin
                    if (pend_any || !fh_eff) begin
                        nxt   = PS_RUN;
                        drain = 1'b1;
                    end else begin
                        nxt = PS_HALT;
                    end
                end else if (state == PS_SG_ENTRY && timer_done) begin
                    nxt = PS_SG;
                end else if (state == PS_SG && snoop_hit) begin
                    nxt = PS_SG_SNP;
                end
            end
            PS_SG_SNP: begin
                nfh = fh_eff;
                if (snoop_done) nxt = PS_SG;
            end
            default: nxt = PS_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state          <= PS_RUN;
            from_halt_q    <= 1'b0;
            halt_cycle_req <= 1'b0;
        end else begin
            state          <= nxt;
            from_halt_q    <= nfh;
            halt_cycle_req <= (state == PS_RUN) && (nxt == PS_HALT);
        end
    end
endmodule

// File: rtl/lps_ctrl.sv
module lps_ctrl
    import lps_pkg::*;
#(
    parameter int NCORES   = 4,
    parameter int SG_DELAY = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCORES-1:0] core_halted,
    input  logic              ext_en,
    input  logic              stop_req,
    input  logic              sgack_resp,
    input  logic              snoop_hit,
    input  logic              snoop_done,
    input  logic              brk_smi,
    input  logic              brk_init,
    input  logic              brk_nmi,
    input  logic              brk_intr,
    input  logic              brk_fsb,
    input  logic              brk_reset,
    output logic [2:0]        pstate,
    output logic              pstate_ext,
    output logic              halt_cycle_req,
    output logic [3:0]        replay_evt
);
    pstate_e  state;
    evt_vec_t evts, replay;
    logic     drain, pend_any, timer_done;

    always_comb begin
        evts           = '0;
        evts[EVT_SMI]  = brk_smi;
        evts[EVT_INIT] = brk_init;
        evts[EVT_NMI]  = brk_nmi;
        evts[EVT_INTR] = brk_intr | brk_fsb;
    end

    lps_sg_timer #(.SG_DELAY(SG_DELAY)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (state == PS_SG_ENTRY),
        .ack  (sgack_resp),
        .done (timer_done)
    );

    lps_evt_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .capture  (holds_events(state)),
        .evts     (evts),
        .wipe     (brk_reset),
        .drain    (drain),
        .pend_any (pend_any),
        .replay   (replay)
    );

    lps_fsm u_fsm (
        .clk            (clk),
        .rst            (rst),
        .all_halted     (&core_halted),
        .stop_req       (stop_req),
        .snoop_hit      (snoop_hit),
        .snoop_done     (snoop_done),
        .evt_any        (|evts),
        .brk_reset      (brk_reset),
        .pend_any       (pend_any),
        .timer_done     (timer_done),
        .state          (state),
        .drain          (drain),
        .halt_cycle_req (halt_cycle_req)
    );

    assign pstate     = state;
    assign pstate_ext = ext_en & is_deep(state);
    assign replay_evt = replay;
endmodule

// File: rtl/lps_ctrl_chk.sv
module lps_ctrl_chk #(
    parameter int NCORES   = 4,
    parameter int SG_DELAY = 20
) (
    input logic              clk,
    input logic              rst,
    input logic [NCORES-1:0] core_halted,
    input logic              ext_en,
    input logic              stop_req,
    input logic              sgack_resp,
    input logic              snoop_done,
    input logic              brk_reset,
    input logic [2:0]        pstate,
    input logic              pstate_ext,
    input logic              halt_cycle_req,
    input logic [3:0]        replay_evt
);
    localparam int WC = $clog2(SG_DELAY + 2);

    logic          seen_q;
    logic [WC-1:0] since_q;

    always_ff @(posedge clk) begin
        if (rst || pstate != 3'd3) begin
            seen_q  <= 1'b0;
            since_q <= '0;
        end else if (!seen_q) begin
            if (sgack_resp) begin
                seen_q  <= 1'b1;
                since_q <= WC'(1);
            end
        end else if (since_q != {WC{1'b1}}) begin
            since_q <= since_q + WC'(1);
        end
    end

    assert_halt_all_cores_R2: assert property (@(posedge clk) disable iff (rst)
        (pstate == 3'd1 && $past(pstate) == 3'd0) |-> $past(&core_halted));

    assert_halt_cycle_once_R2: assert property (@(posedge clk) disable iff (rst)
        halt_cycle_req |-> (pstate == 3'd1 && $past(pstate) == 3'd0));

    assert_sg_delay_R4: assert property (@(posedge clk) disable iff (rst)
        (pstate == 3'd4 && $past(pstate) == 3'd3) |-> ($past(seen_q) && $past(since_q) == WC'(SG_DELAY)));

    assert_halt_snoop_return_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(pstate) == 3'd2 && pstate != 3'd2) |-> (pstate == 3'd1 ? $past(snoop_done) : $past(brk_reset)));

    assert_sg_snoop_return_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(pstate) == 3'd5 && pstate != 3'd5) |-> (pstate == 3'd4 && $past(snoop_done)));

    assert_replay_on_return_R7: assert property (@(posedge clk) disable iff (rst)
        (replay_evt != 4'd0) |-> (pstate == 3'd0 && ($past(pstate) == 3'd3 || $past(pstate) == 3'd4)));

    assert_reset_keeps_sg_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(pstate) == 3'd4 && $past(brk_reset) && $past(stop_req)) |-> (pstate == 3'd4 || pstate == 3'd5));

    assert_ext_tag_R9: assert property (@(posedge clk) disable iff (rst)
        pstate_ext |-> (ext_en && pstate != 3'd0 && pstate != 3'd3));
endmodule

bind lps_ctrl lps_ctrl_chk #(.NCORES(NCORES), .SG_DELAY(SG_DELAY)) u_chk (.*);

// File: tb/sim_lps_ctrl.sv
`timescale 1ns/1ps
module sim_lps_ctrl;
    localparam int NC = 4;
    localparam int DL = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NC-1:0] core_halted = '0;
    logic ext_en = 0, stop_req = 0, sgack_resp = 0, snoop_hit = 0, snoop_done = 0;
    logic brk_smi = 0, brk_init = 0, brk_nmi = 0, brk_intr = 0, brk_fsb = 0, brk_reset = 0;
    logic [2:0] pstate;
    logic pstate_ext, halt_cycle_req;
    logic [3:0] replay_evt;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    lps_ctrl #(.NCORES(NC), .SG_DELAY(DL)) u0 (.*);

    // reference model state
    int m_st = 0, m_cnt = 0;
    bit m_fh = 0, m_armed = 0, m_hcr = 0;
    logic [3:0] m_latch = '0, m_rep = '0;

    function automatic bit deep(int s);
        return s == 1 || s == 2 || s == 4 || s == 5;
    endfunction

    task automatic model_step();
        logic [3:0] ev, pend;
        bit wake, fh, tdone;
        int nx;
        ev = {brk_intr | brk_fsb, brk_nmi, brk_init, brk_smi};
        wake = (ev != 0) || brk_reset;
        nx = m_st; m_hcr = 0; m_rep = '0;
        if (rst) begin
            m_st = 0; m_fh = 0; m_latch = '0; m_armed = 0; m_cnt = 0;
            return;
        end
        tdone = m_armed && m_cnt == 1;
        if (m_st == 3) begin
            if (!m_armed) begin
                if (sgack_resp) begin m_armed = 1; m_cnt = DL; end
            end else if (m_cnt != 0) m_cnt--;
        end else begin
            m_armed = 0; m_cnt = 0;
        end
        if (m_st >= 3) begin
            pend = brk_reset ? 4'd0 : (m_latch | ev);
            fh = m_fh && !brk_reset;
            m_fh = fh;
            m_latch = pend;
            if (m_st == 5) begin
                if (snoop_done) nx = 4;
            end else if (!stop_req) begin
                if (pend != 0 || !fh) begin nx = 0; m_rep = pend; m_latch = '0; end
                else nx = 1;
            end else if (m_st == 3 && tdone) nx = 4;
            else if (m_st == 4 && snoop_hit) nx = 5;
        end else if (m_st == 0) begin
            if (stop_req) begin nx = 3; m_fh = 0; end
            else if ((&core_halted) && !wake) begin nx = 1; m_hcr = 1; end
        end else if (m_st == 1) begin
            if (wake) nx = 0;
            else if (snoop_hit) nx = 2;
            else if (stop_req) begin nx = 3; m_fh = 1; end
        end else begin
            if (brk_reset) nx = 0;
            else if (snoop_done) nx = 1;
        end
        m_st = nx;
    endtask

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk("R1-R8 model pstate", pstate, m_st);
        chk("R9 model pstate_ext", pstate_ext, ext_en && deep(m_st));
        chk("R2 model halt_cycle_req", halt_cycle_req, m_hcr);
        chk("R7 model replay_evt", replay_evt, m_rep);
        {sgack_resp, snoop_hit, snoop_done, brk_smi, brk_init, brk_nmi, brk_intr, brk_fsb, brk_reset} = '0;
    endtask

    task automatic ack_and_wait();
        sgack_resp = 1; tick();
        repeat (DL - 1) tick();
        chk("R4 still in entry after SG_DELAY-1", pstate, 3);
        tick();
        chk("R4 stop grant after SG_DELAY", pstate, 4);
    endtask

    initial begin
        @(negedge clk);
        tick(); tick();
        rst = 0;
        chk("R1 reset pstate", pstate, 0);
        chk("R1 reset replay", replay_evt, 0);
        chk("R1 reset hcr", halt_cycle_req, 0);
        // R2 partial halt
        core_halted = 4'b0111; tick(); tick();
        chk("R2 partial halt stays running", pstate, 0);
        core_halted = '1; tick();
        chk("R2 all halted", pstate, 1);
        chk("R2 halt cycle pulse", halt_cycle_req, 1);
        tick();
        chk("R2 halt cycle one clock", halt_cycle_req, 0);
        // R5 snoop in halt, R3 breaks ignored there
        snoop_hit = 1; tick();
        chk("R5 halt snoop", pstate, 2);
        brk_smi = 1; tick();
        chk("R3 smi ignored in halt snoop", pstate, 2);
        snoop_done = 1; tick();
        chk("R5 return to halt", pstate, 1);
        // R9 ext
        ext_en = 1; tick();
        chk("R9 ext in halt", pstate_ext, 1);
        // R3 bus interrupt wakes
        core_halted = '0; brk_fsb = 1; tick();
        chk("R3 bus interrupt wakes", pstate, 0);
        chk("R9 ext clear in running", pstate_ext, 0);
        // R4 / R7 from running
        stop_req = 1; tick();
        chk("R4 entry", pstate, 3);
        repeat (5) tick();
        chk("R4 waits for ack", pstate, 3);
        ack_and_wait();
        brk_smi = 1; tick(); brk_smi = 1; tick(); brk_init = 1; tick();
        snoop_hit = 1; tick();
        chk("R5 stop grant snoop", pstate, 5);
        stop_req = 0; tick();
        chk("R6 snoop holds exit", pstate, 5);
        snoop_done = 1; tick();
        chk("R5 back to stop grant", pstate, 4);
        tick();
        chk("R6 exit to running", pstate, 0);
        chk("R7 replay once each", replay_evt, 4'b0011);
        tick();
        chk("R7 replay one cycle", replay_evt, 0);
        // R6 halt -> stop grant -> halt
        core_halted = '1; tick(); core_halted = '0;
        chk("R2 halt again", pstate, 1);
        stop_req = 1; tick(); ack_and_wait();
        stop_req = 0; tick();
        chk("R6 return to halt", pstate, 1);
        // R8 reset inside stop grant
        stop_req = 1; tick(); ack_and_wait();
        brk_nmi = 1; tick();
        brk_reset = 1; tick();
        chk("R8 reset keeps stop grant", pstate, 4);
        stop_req = 0; tick();
        chk("R8 exit to running", pstate, 0);
        chk("R8 latch cleared", replay_evt, 0);
        // constrained random
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(39) == 0) stop_req = ~stop_req;
            if ($urandom_range(7) == 0) core_halted = ($urandom_range(1) == 0) ? '1 : NC'($urandom);
            if ($urandom_range(199) == 0) ext_en = ~ext_en;
            sgack_resp = ($urandom_range(9) == 0);
            snoop_hit  = ($urandom_range(14) == 0);
            snoop_done = ($urandom_range(5) == 0);
            brk_smi    = ($urandom_range(59) == 0);
            brk_init   = ($urandom_range(79) == 0);
            brk_nmi    = ($urandom_range(79) == 0);
            brk_intr   = ($urandom_range(59) == 0);
            brk_fsb    = ($urandom_range(99) == 0);
            brk_reset  = ($urandom_range(149) == 0);
            tick();
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule